// File: doc/BRIEF.md
# SLC-96 Receive Datalink Synchronizer

This block sits behind a D4 superframe aligner in a T1 receiver. The aligner hands it one framing bit per frame, together with a frame-valid strobe and a parity flag. The flag says whether the bit came from an odd terminal-framing slot or an even signalling-framing slot. The block uses only the signalling-slot bits. A 72-frame multiframe carries 36 of these bits. The block treats them as a message channel and locks onto it with a 12-bit synchronisation word.

The block starts in `ST_SEARCH`. There it slides a 12-bit window over the signalling-slot bits. When the window holds the sync word, the transition *search→collect* raises the lock flag. In `ST_COLLECT` it takes the next 24 bits. These are the concentrator bits, spoilers, maintenance, alarm and switch fields. It packs them most-significant-bit first into three bytes, and publishes each byte with a fill flag and a byte index.

After the 24th bit the transition *collect→verify* enters `ST_VERIFY`. There the next 12 bits are compared against the sync word one at a time. If all twelve agree, the transition *verify→collect* starts the next multiframe. A single disagreement takes the transition *verify→search*: lock drops and the search starts again from an empty window.

A host clears each fill flag with a one-cycle read acknowledge. A byte that is published while the previous one is still unacknowledged raises an overrun flag.

Top module: `slc96_rx_sync`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `lock_match`, `dl_fill`, `dl_overrun`, `dl_byte` and `dl_index` are all zero.
- R2: The block consumes a bit only when `fr_valid`=1 and `fr_fs_pos`=1. Cycles with `fr_valid`=0, and bits with `fr_fs_pos`=0, leave lock, byte, index and flags unchanged.
- R3: In search, `lock_match` rises in the cycle after a consumed bit completes the sequence 0,0,0,1,1,1,0,0,0,1,1,1 in arrival order. After reset or loss of lock, twelve fresh consumed bits are needed before a match.
- R4: After lock, the next 24 consumed bits are packed with the first bit in bit 7. Each byte appears on `dl_byte`, with `dl_index` = 0, 1, 2 in arrival order, in the cycle after its eighth bit. Spoiler bits pass unaltered and no zero-destuffing is applied.
- R5: `dl_fill` is set when a byte is published and cleared by `rd_ack`. If a publish and `rd_ack` fall in the same cycle, `dl_fill` stays 1 and holds the new byte.
- R6: `dl_overrun` is set when a byte is published while `dl_fill` is 1 and `rd_ack` is 0. It is cleared by `rd_ack`, including an `rd_ack` that coincides with a publish.
- R7: After the 24 data bits, the next 12 consumed bits are compared in order with the sync sequence. If all match, the following 24 bits are collected as the next multiframe's data. The first mismatch drops `lock_match` in the next cycle and returns to search.
- R8: `lock_match` stays 1 throughout collection and sync verification while no mismatch occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_valid | input | 1 | One-cycle strobe: a framing bit is present |
| fr_bit | input | 1 | Framing bit value |
| fr_fs_pos | input | 1 | 1 = bit from an even (signalling) framing slot, 0 = odd (terminal) slot |
| rd_ack | input | 1 | Host read acknowledge, one cycle |
| lock_match | output | 1 | Sync word found and multiframe locked |
| dl_byte | output | 8 | Last published message byte |
| dl_index | output | 2 | Position (0..2) of `dl_byte` within the multiframe |
| dl_fill | output | 1 | Unread byte present |
| dl_overrun | output | 1 | A byte was published over an unread one |

## Verification
Two events can fall in the same cycle: a byte being published and the host's acknowledge of the previous byte. The fill and overrun flags must resolve them so that the new byte stays pending and no overrun is reported. The bench provokes this in one pass by pulsing `rd_ack` exactly on the cycle that carries the eighth bit of every byte. In other passes it acknowledges at random or not at all. A behavioural model with its own queue and counters predicts flags, byte and index on every clock, and any divergence is reported.

// File: rtl/slc96_pkg.sv
package slc96_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_COLLECT = 2'd1,
        ST_VERIFY  = 2'd2
    } sync_state_t;
endpackage

// File: rtl/slc96_sync_search.sv
// Sliding window over consumed bits; flags a hit when the window equals the sync word.
module slc96_sync_search #(
    parameter int              SYNC_LEN = 12,
    parameter logic [SYNC_LEN-1:0] SYNC_PAT = 12'b000111000111
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic restart,
    input  logic bit_in,
    output logic hit
);
    logic [SYNC_LEN-1:0] window;
    logic [SYNC_LEN-1:0] window_nxt;

    assign window_nxt = {window[SYNC_LEN-2:0], bit_in};
    assign hit        = shift_en && (window_nxt == SYNC_PAT);

    // All-ones fill: the word starts with 0, so no stale history can complete it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        window <= '1;
        else if (restart)  window <= '1;
        else if (shift_en) window <= window_nxt;
    end
endmodule

// File: rtl/slc96_field_packer.sv
// Packs message bits MSB-first into bytes and manages fill / overrun flags.
module slc96_field_packer #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 5,
    localparam int BIT_W = $clog2(BYTE_W),
    localparam int IDX_W = CNT_W - BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic [CNT_W-1:0]  bit_pos,
    input  logic              rd_ack,
    output logic [BYTE_W-1:0] out_byte,
    output logic [IDX_W-1:0]  out_idx,
    output logic              fill,
    output logic              overrun
);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] acc_nxt;
    logic              publish;

    assign acc_nxt = {acc[BYTE_W-2:0], bit_in};
    assign publish = bit_en && (bit_pos[BIT_W-1:0] == BIT_W'(BYTE_W-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc      <= '0;
            out_byte <= '0;
            out_idx  <= '0;
        end else if (bit_en) begin
            acc <= acc_nxt;
            if (publish) begin
                out_byte <= acc_nxt;
                out_idx  <= bit_pos[CNT_W-1:BIT_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (publish)     fill <= 1'b1;
            else if (rd_ack) fill <= 1'b0;
            if (publish && fill && !rd_ack) overrun <= 1'b1;
            else if (rd_ack)                overrun <= 1'b0;
        end
    end

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !publish) |=> !fill);
    assert_publish_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        publish |=> fill);
    assert_overrun_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (publish && fill && !rd_ack) |=> overrun);
    assert_ack_clears_ovr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !overrun);
endmodule

// File: rtl/slc96_rx_sync.sv
module slc96_rx_sync #(
    parameter int                  SYNC_LEN  = 12,
    parameter int                  DATA_BITS = 24,
    parameter int                  BYTE_W    = 8,
    parameter logic [SYNC_LEN-1:0] SYNC_PAT  = 12'b000111000111,
    localparam int MAXC  = (DATA_BITS > SYNC_LEN) ? DATA_BITS : SYNC_LEN,
    localparam int CNT_W = $clog2(MAXC),
    localparam int IDX_W = CNT_W - $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fr_valid,
    input  logic              fr_bit,
    input  logic              fr_fs_pos,
    input  logic              rd_ack,
    output logic              lock_match,
    output logic [BYTE_W-1:0] dl_byte,
    output logic [IDX_W-1:0]  dl_index,
    output logic              dl_fill,
    output logic              dl_overrun
);
    import slc96_pkg::*;

    sync_state_t         state, state_nxt;
    logic [CNT_W-1:0]    cnt;
    logic [SYNC_LEN-1:0] vpat;
    logic                take, hit, mismatch;
    logic                shift_en, collect_en, restart;

    assign take     = fr_valid && fr_fs_pos;
    assign mismatch = (state == ST_VERIFY) && take && (fr_bit != vpat[SYNC_LEN-1]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SEARCH;
        else        state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SEARCH:  if (hit) state_nxt = ST_COLLECT;
            ST_COLLECT: if (take && cnt == CNT_W'(DATA_BITS-1)) state_nxt = ST_VERIFY;
            ST_VERIFY: begin
                if (mismatch)                                 state_nxt = ST_SEARCH;
                else if (take && cnt == CNT_W'(SYNC_LEN-1))   state_nxt = ST_COLLECT;
            end
            default: state_nxt = ST_SEARCH;
        endcase
    end

    // Outputs and strobes
    always_comb begin
        lock_match = 1'b0;
        shift_en   = 1'b0;
        collect_en = 1'b0;
        restart    = 1'b0;
        unique case (state)
            ST_SEARCH:  shift_en = take;
            ST_COLLECT: begin lock_match = 1'b1; collect_en = take; end
            ST_VERIFY:  begin lock_match = 1'b1; restart = mismatch; end
            default:    ;
        endcase
    end

    // Position counter and sync-verify shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            vpat <= SYNC_PAT;
        end else if (state != state_nxt) begin
            cnt  <= '0;
            vpat <= SYNC_PAT;
        end else if (take && state != ST_SEARCH) begin
            cnt  <= cnt + 1'b1;
            if (state == ST_VERIFY) vpat <= {vpat[SYNC_LEN-2:0], 1'b0};
        end
    end

    slc96_sync_search #(.SYNC_LEN(SYNC_LEN), .SYNC_PAT(SYNC_PAT)) u_search (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .restart(restart),
        .bit_in(fr_bit), .hit(hit)
    );

    slc96_field_packer #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .bit_en(collect_en), .bit_in(fr_bit),
        .bit_pos(cnt), .rd_ack(rd_ack), .out_byte(dl_byte), .out_idx(dl_index),
        .fill(dl_fill), .overrun(dl_overrun)
    );

    assert_idle_no_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(lock_match) && $stable(dl_byte) && $stable(dl_index)));
    assert_lock_from_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> lock_match);
    assert_mismatch_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> !lock_match);
    assert_hold_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_match && !mismatch) |=> lock_match);
endmodule

// File: tb/sim_slc96_rx_sync.sv
module sim_slc96_rx_sync;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fr_valid = 1'b0, fr_bit = 1'b0, fr_fs_pos = 1'b0, rd_ack = 1'b0;
    logic lock_match, dl_fill, dl_overrun;
    logic [7:0] dl_byte;
    logic [1:0] dl_index;

    always #2.5 clk = ~clk;

    slc96_rx_sync u0 (
        .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_bit(fr_bit),
        .fr_fs_pos(fr_fs_pos), .rd_ack(rd_ack), .lock_match(lock_match),
        .dl_byte(dl_byte), .dl_index(dl_index), .dl_fill(dl_fill),
        .dl_overrun(dl_overrun)
    );

    int checks = 0, errors = 0, cycles = 0, ack_mode = 0;
    bit done = 0;
    localparam logic [11:0] SYNC = 12'b000111000111;

    // Behavioural reference
    bit hist[$];
    int m_state = 0, m_cnt = 0, m_acc = 0, m_byte = 0, m_idx = 0;
    bit m_fill = 0, m_ovr = 0, m_lock = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete(); m_state = 0; m_cnt = 0; m_acc = 0; m_byte = 0;
            m_idx = 0; m_fill = 0; m_ovr = 0;
        end else begin
            bit pub;
            pub = 0;
            if (fr_valid && fr_fs_pos) begin
                if (m_state == 0) begin
                    bit ok;
                    hist.push_back(fr_bit);
                    if (hist.size() > 12) void'(hist.pop_front());
                    ok = (hist.size() == 12);
                    for (int i = 0; i < hist.size(); i++) if (hist[i] != SYNC[11-i]) ok = 0;
                    if (ok) begin m_state = 1; m_cnt = 0; hist.delete(); end
                end else if (m_state == 1) begin
                    m_acc = ((m_acc << 1) | fr_bit) & 255;
                    if (m_cnt % 8 == 7) begin pub = 1; m_byte = m_acc; m_idx = m_cnt / 8; end
                    m_cnt++;
                    if (m_cnt == 24) begin m_state = 2; m_cnt = 0; end
                end else begin
                    if (fr_bit != SYNC[11-m_cnt]) begin m_state = 0; m_cnt = 0; hist.delete(); end
                    else begin m_cnt++; if (m_cnt == 12) begin m_state = 1; m_cnt = 0; end end
                end
            end
            if (pub) begin
                m_ovr = (m_fill && !rd_ack) ? 1'b1 : (rd_ack ? 1'b0 : m_ovr);
                m_fill = 1;
            end else if (rd_ack) begin
                m_fill = 0; m_ovr = 0;
            end
        end
        m_lock = (m_state != 0);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(lock_match == m_lock, "R3/R7/R8 lock_match", lock_match, m_lock);
            chk(dl_fill == m_fill, "R5 dl_fill", dl_fill, m_fill);
            chk(dl_overrun == m_ovr, "R6 dl_overrun", dl_overrun, m_ovr);
            chk(dl_byte == m_byte[7:0], "R4 dl_byte", dl_byte, m_byte);
            chk(dl_index == m_idx[1:0], "R4 dl_index", dl_index, m_idx);
        end
        if (!done && cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    function automatic bit ack_pick(input bit completing);
        case (ack_mode)
            0: return dl_fill && ($urandom % 2 == 1);
            2: return completing;
            default: return 1'b0;
        endcase
    endfunction

    // One framing bit, then 0..2 idle cycles with junk on the inputs (R2)
    task automatic send_bit(input bit b, input bit fs, input bit completing);
        int gap;
        @(negedge clk);
        fr_valid = 1; fr_bit = b; fr_fs_pos = fs; rd_ack = ack_pick(completing);
        gap = $urandom % 3;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            fr_valid = 0; fr_bit = $urandom % 2; fr_fs_pos = $urandom % 2;
            rd_ack = (ack_mode == 2) ? 1'b0 : ack_pick(1'b0);
        end
    endtask

    task automatic send_mf(input logic [11:0] sync, input logic [23:0] data);
        for (int i = 0; i < 72; i++) begin
            int k;
            k = i / 2;
            if (i % 2 == 0) send_bit(((i / 2) % 2) == 0, 1'b0, 1'b0);
            else if (k < 12) send_bit(sync[11-k], 1'b1, 1'b0);
            else send_bit(data[23-(k-12)], 1'b1, ((k - 12) % 8) == 7);
        end
    endtask

    function automatic logic [23:0] mk_data(input logic [10:0] c, input logic [2:0] m,
                                            input logic [1:0] a, input logic [3:0] s);
        return {c, 3'b010, m, a, s, 1'b1};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk(lock_match == 0 && dl_fill == 0 && dl_overrun == 0, "R1 flags in reset",
            {lock_match, dl_fill, dl_overrun}, 0);
        chk(dl_byte == 0 && dl_index == 0, "R1 byte/index in reset", dl_byte, 0);
        rst_n = 1;
        @(negedge clk);
        chk(lock_match == 0 && dl_fill == 0, "R1 after release", lock_match, 0);
        // R2: sync word sent only on terminal slots must not lock
        for (int r = 0; r < 3; r++)
            for (int k = 0; k < 12; k++) send_bit(SYNC[11-k], 1'b0, 1'b0);
        @(negedge clk);
        chk(lock_match == 0, "R2 terminal-slot bits ignored", lock_match, 0);
        // R3/R4/R5: lock and data with random acks
        ack_mode = 0;
        send_mf(12'hABC, 24'h5A5A5A);
        send_mf(SYNC, mk_data(11'h5A3, 3'b101, 2'b10, 4'b0110));
        send_mf(SYNC, mk_data(11'h7FF, 3'b000, 2'b11, 4'b1001));
        send_mf(SYNC, 24'h000000);
        // R6: no acks, overrun builds up
        ack_mode = 1;
        send_mf(SYNC, mk_data(11'h001, 3'b111, 2'b01, 4'b1111));
        send_mf(SYNC, 24'hFFFFFF);
        // R5/R6: ack coincides with each publish
        ack_mode = 2;
        send_mf(SYNC, mk_data(11'h2AA, 3'b010, 2'b00, 4'b0101));
        send_mf(SYNC, mk_data(11'h155, 3'b011, 2'b10, 4'b1010));
        // R7: corrupted sync word drops lock
        ack_mode = 0;
        send_mf(12'b000111000101, 24'h123456);
        send_mf(12'b100111000111, 24'h654321);
        send_mf(SYNC, 24'hC3C3C3);
        send_mf(SYNC, mk_data(11'h0F0, 3'b100, 2'b01, 4'b0011));
        send_mf(SYNC, 24'h3C3C3C);
        repeat (4) @(negedge clk);
        chk(lock_match == 1, "R8 relocked at end", lock_match, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule